// File: doc/BRIEF.md
# Command-Processor Microcontroller ALU

This block is the arithmetic and logic unit of a small 32-bit command-processor microcontroller. A decoder upstream hands it one operation at a time: a 5-bit opcode, the value and index of the first source register, and a second operand. The second operand is either a register value with its index or a 16-bit immediate. The unit computes a 32-bit result. It returns that result together with the destination index, a write-enable and a carry/borrow flag. The flag lets firmware build 64-bit add and subtract from a low-word step followed by a high-word step.

The three-way compare produces a fixed pattern meant for single-bit testing. Bit 1 of that pattern is set exactly when the first operand is at most the second. Firmware therefore reaches ≤ and > with one bit test. A move-immediate operation shifts the 16-bit immediate left by an encoded amount. A shift of 16 places it in the upper half-word, so the unit needs no separate load-upper operation.

Operations enter on a valid/ready stream and leave on a second valid/ready stream. There is one registered stage between them. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A transfer happens on a rising edge where both valid and ready are high, and its result appears on the output one cycle later. While `out_valid` is high and `out_ready` is low, every output holds its value and no new operation is taken.

Top module: `cp_alu`

## Requirements
- R1: Opcode 0 (add) returns src1+src2 mod 2^32 and sets the flag to the carry out. Opcode 2 (subtract) returns src1−src2 mod 2^32 and sets the flag to the borrow, which is 1 when src1 < src2 unsigned.
- R2: Opcode 1 (high add) returns src1+src2+flag and opcode 3 (high subtract) returns src1−src2−flag; each replaces the flag with its own carry or borrow. Every other opcode, including unknown ones, leaves the flag unchanged.
- R3: Opcodes 4, 5 and 6 return the bitwise AND, OR and XOR of the operands. Opcode 7 returns the bitwise inverse of the second operand alone.
- R4: Opcodes 8 (shift left), 9 (logical shift right), 10 (arithmetic shift right, copying bit 31) and 11 (rotate left) take the shift amount from bits 4:0 of the second operand only.
- R5: Opcode 12 returns the zero-extended product of bits 7:0 of both operands. Opcode 13 returns the smaller and opcode 14 the larger of the operands, compared as unsigned values.
- R6: Opcode 15 compares unsigned. It returns 0x00 when src1 > src2, 0x2b when they are equal and 0x1e when src1 < src2, so result bit 1 is 1 exactly when src1 ≤ src2.
- R7: With `in_use_imm` high, the second operand is the 16-bit immediate zero-extended to 32 bits, whatever the register index and value.
- R8: Opcode 16 returns the immediate, zero-extended, shifted left by `in_shamt` (0 to 31), with bits above 31 dropped.
- R9: A source index of 0 reads as zero whatever value accompanies it. A destination index of 0 gives `out_wr_en` = 0.
- R10: `in_ready` = `!out_valid || out_ready`. An accepted operation appears on the output on the next cycle. While `out_valid && !out_ready`, the output values stay unchanged and the flag is not altered.
- R11: During reset, `out_valid`, `out_wr_en` and `out_carry` are 0 and `in_ready` is 1.
- R12: Opcodes 17 to 31 return a result of 0 with `out_wr_en` = 0 and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 5 | Opcode |
| in_src1_idx | input | IDX_W (5) | First source register index |
| in_src1 | input | DATA_W (32) | First source value |
| in_src2_idx | input | IDX_W (5) | Second source register index |
| in_src2 | input | DATA_W (32) | Second source value |
| in_use_imm | input | 1 | Use immediate as second operand |
| in_imm | input | IMM_W (16) | Immediate |
| in_shamt | input | SHAMT_W (5) | Move-immediate shift amount |
| in_dst_idx | input | IDX_W (5) | Destination register index |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | DATA_W (32) | Result |
| out_dst_idx | output | IDX_W (5) | Destination index |
| out_wr_en | output | 1 | Result should be written |
| out_carry | output | 1 | Carry/borrow flag after the operation |

## Verification
Every opcode from 0 to 15 is swept over all pairs drawn from eight corner values. These include zero, one, both sign boundaries, all-ones, and values whose upper bits would change a shift amount if they were not masked. The sweep separates the unsigned from the signed treatment of compare, min and max, and masked from unmasked shift amounts. Explicit two-word chains confirm that the high-word steps consume the saved flag. The move-immediate sweep covers every shift amount for three immediates, which shows where bits are truncated. Zero indices, the immediate path, unknown opcodes and a stalled consumer each get directed patterns that separate them from the ordinary data path.

// File: rtl/cp_alu_pkg.sv
package cp_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDHI = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBHI = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOT   = 5'd7,
    OP_SHL   = 5'd8,
    OP_USHR  = 5'd9,
    OP_ISHR  = 5'd10,
    OP_ROTL  = 5'd11,
    OP_MUL8  = 5'd12,
    OP_MIN   = 5'd13,
    OP_MAX   = 5'd14,
    OP_CMP   = 5'd15,
    OP_MOVI  = 5'd16
  } op_e;

  typedef enum logic [1:0] {
    SH_LEFT,
    SH_LRIGHT,
    SH_ARIGHT,
    SH_ROTL
  } shmode_e;

  // three-way compare codes, bit 1 set for less-or-equal
  localparam logic [7:0] CMP_GT = 8'h00;
  localparam logic [7:0] CMP_EQ = 8'h2b;
  localparam logic [7:0] CMP_LT = 8'h1e;
endpackage

// File: rtl/cp_alu_operands.sv
module cp_alu_operands #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  src1_idx,
  input  logic [DATA_W-1:0] src1,
  input  logic [IDX_W-1:0]  src2_idx,
  input  logic [DATA_W-1:0] src2,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  logic [DATA_W-1:0] reg_b;

  // index zero is the hard-wired zero register
  assign opa   = (src1_idx == '0) ? '0 : src1;
  assign reg_b = (src2_idx == '0) ? '0 : src2;
  assign opb   = use_imm ? DATA_W'(imm) : reg_b;
endmodule

// File: rtl/cp_alu_addsub.sv
module cp_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              flag_in,
  input  logic              is_sub,
  input  logic              use_flag,
  output logic [DATA_W-1:0] sum,
  output logic              flag_out
);
  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W:0]   total;

  // subtract as a + ~b + 1, less one when a borrow is pending
  assign b_eff = is_sub ? ~b : b;
  always_comb begin
    if (is_sub) cin = use_flag ? ~flag_in : 1'b1;
    else        cin = use_flag ?  flag_in : 1'b0;
  end

  assign total    = {1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(cin);
  assign sum      = total[DATA_W-1:0];
  assign flag_out = is_sub ? ~total[DATA_W] : total[DATA_W];
endmodule

// File: rtl/cp_alu_shifter.sv
module cp_alu_shifter
  import cp_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  shmode_e            mode,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] stg [SHAMT_W+1];
  logic              fill;

  assign fill   = (mode == SH_ARIGHT) & din[DATA_W-1];
  assign stg[0] = din;

  // logarithmic barrel: stage k moves by 2^k when amt[k] is set
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [DATA_W-1:0] cur, to_left, to_right, to_rot;
    assign cur      = stg[k];
    assign to_left  = {cur[DATA_W-1-D:0], {D{1'b0}}};
    assign to_rot   = {cur[DATA_W-1-D:0], cur[DATA_W-1:DATA_W-D]};
    assign to_right = {{D{fill}}, cur[DATA_W-1:D]};
    assign stg[k+1] = !amt[k]            ? cur     :
                      (mode == SH_LEFT)  ? to_left :
                      (mode == SH_ROTL)  ? to_rot  : to_right;
  end

  assign dout = stg[SHAMT_W];
endmodule

// File: rtl/cp_alu_cmp.sv
module cp_alu_cmp
  import cp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] code,
  output logic [DATA_W-1:0] vmin,
  output logic [DATA_W-1:0] vmax
);
  logic lt, eq;

  assign lt   = a < b;
  assign eq   = a == b;
  assign code = eq ? DATA_W'(CMP_EQ) : lt ? DATA_W'(CMP_LT) : DATA_W'(CMP_GT);
  assign vmin = lt ? a : b;
  assign vmax = lt ? b : a;
endmodule

// File: rtl/cp_alu.sv
module cp_alu
  import cp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5,
  parameter int MUL_W  = 8,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_op,
  input  logic [IDX_W-1:0]   in_src1_idx,
  input  logic [DATA_W-1:0]  in_src1,
  input  logic [IDX_W-1:0]   in_src2_idx,
  input  logic [DATA_W-1:0]  in_src2,
  input  logic               in_use_imm,
  input  logic [IMM_W-1:0]   in_imm,
  input  logic [SHAMT_W-1:0] in_shamt,
  input  logic [IDX_W-1:0]   in_dst_idx,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_result,
  output logic [IDX_W-1:0]   out_dst_idx,
  output logic               out_wr_en,
  output logic               out_carry
);
  localparam int PROD_W = 2 * MUL_W;

  op_e               op;
  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W-1:0] sum, cmp_code, vmin, vmax, sh_out, sh_in, res;
  logic [PROD_W-1:0] prod;
  logic              flag_q, flag_nxt, sets_flag, known, accept;
  logic [SHAMT_W-1:0] sh_amt;
  shmode_e           sh_mode;

  assign op = op_e'(in_op);

  cp_alu_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_opnd (
    .src1_idx(in_src1_idx), .src1(in_src1),
    .src2_idx(in_src2_idx), .src2(in_src2),
    .use_imm(in_use_imm),   .imm(in_imm),
    .opa(opa),              .opb(opb)
  );

  cp_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(opa), .b(opb), .flag_in(flag_q),
    .is_sub((op == OP_SUB) || (op == OP_SUBHI)),
    .use_flag((op == OP_ADDHI) || (op == OP_SUBHI)),
    .sum(sum), .flag_out(flag_nxt)
  );

  // move-immediate shares the barrel with the shift operations
  always_comb begin
    sh_in   = opa;
    sh_amt  = opb[SHAMT_W-1:0];
    sh_mode = SH_LEFT;
    case (op)
      OP_USHR: sh_mode = SH_LRIGHT;
      OP_ISHR: sh_mode = SH_ARIGHT;
      OP_ROTL: sh_mode = SH_ROTL;
      OP_MOVI: begin
        sh_in  = DATA_W'(in_imm);
        sh_amt = in_shamt;
      end
      default: sh_mode = SH_LEFT;
    endcase
  end

  cp_alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .din(sh_in), .amt(sh_amt), .mode(sh_mode), .dout(sh_out)
  );

  cp_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a(opa), .b(opb), .code(cmp_code), .vmin(vmin), .vmax(vmax)
  );

  assign prod = PROD_W'(opa[MUL_W-1:0]) * PROD_W'(opb[MUL_W-1:0]);

  always_comb begin
    known     = 1'b1;
    sets_flag = 1'b0;
    res       = '0;
    case (op)
      OP_ADD, OP_ADDHI, OP_SUB, OP_SUBHI: begin
        res       = sum;
        sets_flag = 1'b1;
      end
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_NOT:  res = ~opb;
      OP_SHL, OP_USHR, OP_ISHR, OP_ROTL, OP_MOVI: res = sh_out;
      OP_MUL8: res = DATA_W'(prod);
      OP_MIN:  res = vmin;
      OP_MAX:  res = vmax;
      OP_CMP:  res = cmp_code;
      default: known = 1'b0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dst_idx <= '0;
      out_wr_en   <= 1'b0;
      flag_q      <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= res;
      out_dst_idx <= in_dst_idx;
      out_wr_en   <= known && (in_dst_idx != '0);
      if (sets_flag) flag_q <= flag_nxt;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assign out_carry = flag_q;
endmodule

// File: rtl/cp_alu_chk.sv
module cp_alu_chk
  import cp_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int IDX_W   = 5,
  parameter int SHAMT_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [OP_W-1:0]    in_op,
  input logic [IMM_W-1:0]   in_imm,
  input logic [SHAMT_W-1:0] in_shamt,
  input logic [IDX_W-1:0]   in_dst_idx,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_result,
  input logic [IDX_W-1:0]   out_dst_idx,
  input logic               out_wr_en,
  input logic               out_carry
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_carry) && $stable(out_dst_idx) && $stable(out_wr_en))); // R10

  AST_CMP_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_CMP) |=> (out_result == DATA_W'(CMP_GT) ||
      out_result == DATA_W'(CMP_EQ) || out_result == DATA_W'(CMP_LT))); // R6

  AST_ZERO_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_dst_idx == '0) |=> !out_wr_en); // R9

  AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op > OP_SUBHI) |=> out_carry == $past(out_carry)); // R2

  AST_MOVI_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_MOVI && in_shamt == '0) |=>
      out_result == DATA_W'($past(in_imm))); // R8
endmodule

bind cp_alu cp_alu_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .SHAMT_W(SHAMT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_imm(in_imm), .in_shamt(in_shamt),
  .in_dst_idx(in_dst_idx), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_dst_idx(out_dst_idx),
  .out_wr_en(out_wr_en), .out_carry(out_carry)
);

// File: tb/cp_alu_tb.sv
module cp_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [4:0]  in_src1_idx = '0;
  logic [31:0] in_src1 = '0;
  logic [4:0]  in_src2_idx = '0;
  logic [31:0] in_src2 = '0;
  logic        in_use_imm = 1'b0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic [4:0]  in_dst_idx = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [4:0]  out_dst_idx;
  logic        out_wr_en;
  logic        out_carry;

  int   n_chk = 0;
  int   n_bad = 0;
  logic mflag = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  cp_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src1_idx(in_src1_idx), .in_src1(in_src1),
    .in_src2_idx(in_src2_idx), .in_src2(in_src2), .in_use_imm(in_use_imm),
    .in_imm(in_imm), .in_shamt(in_shamt), .in_dst_idx(in_dst_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_dst_idx(out_dst_idx), .out_wr_en(out_wr_en), .out_carry(out_carry)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference: returns {flag, result}
  function automatic logic [32:0] ref_alu(int op, logic [31:0] a, logic [31:0] b,
                                          logic [15:0] imm, logic [4:0] sh, logic f);
    longint unsigned t;
    logic [31:0] r;
    logic nf = f;
    int s = int'(b[4:0]);
    case (op)
      0: begin t = longint'(a) + longint'(b); r = t[31:0]; nf = t[32]; end
      1: begin t = longint'(a) + longint'(b) + longint'(f); r = t[31:0]; nf = t[32]; end
      2: begin r = a - b; nf = (a < b); end
      3: begin r = a - b - 32'(f); nf = (longint'(a) < longint'(b) + longint'(f)); end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~b;
      8: r = a << s;
      9: r = a >> s;
      10: r = 32'($signed(a) >>> s);
      11: r = (s == 0) ? a : ((a << s) | (a >> (32 - s)));
      12: r = 32'(a[7:0]) * 32'(b[7:0]);
      13: r = (a < b) ? a : b;
      14: r = (a > b) ? a : b;
      15: r = (a > b) ? 32'h00 : (a == b) ? 32'h2b : 32'h1e;
      16: r = 32'(imm) << sh;
      default: r = '0;
    endcase
    return {nf, r};
  endfunction

  function automatic string req_of(int op);
    if (op == 0 || op == 2) return "R1";
    if (op == 1 || op == 3) return "R2";
    if (op >= 4 && op <= 7) return "R3";
    if (op >= 8 && op <= 11) return "R4";
    if (op >= 12 && op <= 14) return "R5";
    if (op == 15) return "R6";
    if (op == 16) return "R8";
    return "R12";
  endfunction

  task automatic exercise(string req, int op, logic [4:0] i1, logic [31:0] a,
                          logic [4:0] i2, logic [31:0] b, logic ui,
                          logic [15:0] imm, logic [4:0] sh, logic [4:0] dst);
    logic [31:0] ea, eb, er;
    logic [32:0] m;
    logic known, ef;
    @(negedge clk);
    in_op = 5'(op); in_src1_idx = i1; in_src1 = a; in_src2_idx = i2;
    in_src2 = b; in_use_imm = ui; in_imm = imm; in_shamt = sh;
    in_dst_idx = dst; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ea = (i1 == 0) ? 32'h0 : a;
    eb = ui ? 32'(imm) : ((i2 == 0) ? 32'h0 : b);
    known = (op <= 16);
    m = ref_alu(op, ea, eb, imm, sh, mflag);
    er = known ? m[31:0] : 32'h0;
    ef = (op <= 3) ? m[32] : mflag;
    check(req, "result", out_result, er);
    check((op <= 3) ? req : "R2", "flag", 32'(out_carry), 32'(ef));
    check((dst == 0) ? "R9" : req, "wr_en", 32'(out_wr_en), 32'(known && dst != 0));
    mflag = ef;
  endtask

  logic [31:0] cv [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                          32'hffffffff, 32'h0000002b, 32'h12345678, 32'hfffe0021};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11", "out_valid", 32'(out_valid), 32'h0);
    check("R11", "out_wr_en", 32'(out_wr_en), 32'h0);
    check("R11", "out_carry", 32'(out_carry), 32'h0);
    check("R11", "in_ready", 32'(in_ready), 32'h1);
    rst_n = 1'b1;

    // sweep of opcodes 0..15 over corner pairs
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          exercise(req_of(op), op, 5'd3, cv[i], 5'd4, cv[j], 1'b0, 16'h0, 5'd0, 5'd7);

    // R6 bit 1 encodes less-or-equal
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        exercise("R6", 15, 5'd1, cv[i], 5'd2, cv[j], 1'b0, 16'h0, 5'd0, 5'd9);
        check("R6", "le bit", 32'(out_result[1]), 32'(cv[i] <= cv[j]));
      end

    // R1/R2 64-bit chains: 0x1_ffffffff + 1, then 0x1_00000000 - 1
    exercise("R1", 0, 5'd2, 32'hffffffff, 5'd3, 32'h1, 1'b0, 16'h0, 5'd0, 5'd4);
    exercise("R2", 1, 5'd2, 32'h1, 5'd3, 32'h0, 1'b0, 16'h0, 5'd0, 5'd5);
    check("R2", "hi add", out_result, 32'h2);
    exercise("R1", 2, 5'd2, 32'h0, 5'd3, 32'h1, 1'b0, 16'h0, 5'd0, 5'd4);
    exercise("R2", 3, 5'd2, 32'h1, 5'd3, 32'h0, 1'b0, 16'h0, 5'd0, 5'd5);
    check("R2", "hi sub", out_result, 32'h0);

    // R8 move-immediate over every shift amount
    for (int s = 0; s < 32; s++) begin
      exercise("R8", 16, 5'd0, 32'h0, 5'd0, 32'h0, 1'b0, 16'h1234, 5'(s), 5'd6);
      exercise("R8", 16, 5'd0, 32'h0, 5'd0, 32'h0, 1'b0, 16'hffff, 5'(s), 5'd6);
      exercise("R8", 16, 5'd0, 32'h0, 5'd0, 32'h0, 1'b0, 16'h0001, 5'(s), 5'd6);
    end

    // R7 immediate path, register index and value ignored
    exercise("R7", 0, 5'd3, 32'h00010000, 5'd4, 32'hdeadbeef, 1'b1, 16'hffff, 5'd0, 5'd8);
    exercise("R7", 5, 5'd3, 32'hf0000000, 5'd0, 32'h12345678, 1'b1, 16'h8001, 5'd0, 5'd8);
    exercise("R7", 7, 5'd3, 32'h0, 5'd9, 32'hffffffff, 1'b1, 16'h1234, 5'd0, 5'd8);
    exercise("R7", 15, 5'd3, 32'h2b, 5'd4, 32'h0, 1'b1, 16'h002b, 5'd0, 5'd8);

    // R9 zero register reads and zero destination
    exercise("R9", 0, 5'd0, 32'hdead0000, 5'd4, 32'h5, 1'b0, 16'h0, 5'd0, 5'd8);
    exercise("R9", 5, 5'd3, 32'h0f0f0f0f, 5'd0, 32'hffffffff, 1'b0, 16'h0, 5'd0, 5'd8);
    exercise("R9", 4, 5'd3, 32'hffffffff, 5'd4, 32'hffffffff, 1'b0, 16'h0, 5'd0, 5'd0);

    // R12 unknown opcodes with flag set beforehand
    exercise("R1", 0, 5'd3, 32'hffffffff, 5'd4, 32'h1, 1'b0, 16'h0, 5'd0, 5'd8);
    for (int op = 17; op < 32; op++)
      exercise("R12", op, 5'd3, 32'h1234, 5'd4, 32'h5678, 1'b0, 16'h0, 5'd0, 5'd8);

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 5'd0; in_src1_idx = 5'd1; in_src1 = 32'd10; in_src2_idx = 5'd2;
    in_src2 = 32'd20; in_use_imm = 1'b0; in_dst_idx = 5'd5; in_valid = 1'b1;
    @(negedge clk);
    check("R10", "first result", out_result, 32'd30);
    check("R10", "valid", 32'(out_valid), 32'h1);
    in_op = 5'd2; in_src1 = 32'd50; in_src2 = 32'd8;
    for (int c = 0; c < 3; c++) begin
      check("R10", "stall ready", 32'(in_ready), 32'h0);
      @(negedge clk);
      check("R10", "held result", out_result, 32'd30);
      check("R10", "held flag", 32'(out_carry), 32'h0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "second result", out_result, 32'd42);
    check("R10", "second valid", 32'(out_valid), 32'h1);
    @(negedge clk);
    check("R10", "drained", 32'(out_valid), 32'h0);
    mflag = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule